// File: doc/BRIEF.md
# Virtually Indexed, Physically Tagged Set-Associative Cache Lookup

This block is the lookup stage of a 4-way set-associative cache. The total capacity is 8 KB and each line holds 16 bytes.

- **Indexing.** The block selects the set from the untranslated (virtual) request address. It starts reading all tag and data ways on the clock edge that accepts the request.
- **Hit decision.** A translation unit outside the block supplies the physical address and a fault flag during the request cycle. The block registers them and compares them against the stored physical tags in the following cycle. Hits are therefore decided by physical address, while placement follows the virtual address.
- **Aliasing.** The smallest page is 1 KB, so index bit 10 comes from the page number. Two virtual aliases of one physical line that differ in that bit end up in two different sets. The block neither merges nor detects these copies; keeping aliases apart is left to software.

**Misses.**
- A read miss fetches the line from memory as four 32-bit beats. The line goes into a way chosen by a per-set tree pseudo-LRU, and the requested word is returned after the last beat.
- A write that hits updates only the enabled bytes. A write that misses leaves the cache unchanged.
- A translation fault produces an error response and never starts a line fetch.

**Invalidation.** A single pulse on `inv_all` clears every valid bit. This sweeps one set per cycle, and requests are held off for the whole sweep.

Top module: `vipt_cache`

## Requirements
- R1: The geometry is 128 sets by 4 ways by 16-byte lines. The set is virtual address bits [10:4], and the word within the line is virtual bits [3:2].
- R2: A request is taken when `req_valid` and `req_ready` are both high. `xl_paddr` and `xl_fault` are sampled in that same cycle. For a hit or a fault, `resp_valid` is high for exactly one cycle, two clock edges after the accepting edge. `req_ready` is low while a request is in flight.
- R3: A hit needs a valid way in the selected set whose stored tag equals physical bits [31:10], which include the translated index bit 10. At most one way of a set hits.
- R4: Two virtual addresses that differ in bit 10 but map to one physical line are filled into two different sets, and both later hit. A write through one alias changes only that copy, so the other alias still returns the old data.
- R5: With the virtual address equal to the physical address, the cache acts as a plain physically addressed cache. A first read misses, and every later read of the line hits with the memory contents.
- R6: When `xl_fault` is high, the response has `resp_err`=1 and `resp_hit`=0. No line fetch starts, and no cached line, valid bit or replacement state changes.
- R7: On a read miss, `fill_req` rises and stays high with a stable `fill_addr`, equal to the physical line base with bits [3:0] zero, until the last beat. Beats arrive on `fill_valid` in word order 0, 1, 2, 3. The response then has `resp_hit`=0 and the requested word, and later reads of the line hit.
- R8: The victim comes from a 3-bit tree per set. Bit 0 set to 0 selects ways 0–1, with bit 1 choosing way 1 over way 0. Bit 0 set to 1 selects ways 2–3, with bit 2 choosing way 3 over way 2. Every hit or fill points the tree away from the used way. From reset, five distinct lines in one set fill ways 0, 2, 1, 3 and then evict way 0.
- R9: A write hit stores only the bytes whose `req_be` bit is set (`req_be` bit n covers data bits [8n+7:8n]) and responds with `resp_hit`=1.
- R10: A write miss responds with `resp_hit`=0, raises no `fill_req`, and allocates no line.
- R11: `inv_all`, taken while idle, clears every valid bit one set per cycle. `req_ready` stays low for exactly 128 cycles during the sweep, and afterwards every read misses.
- R12: After reset, `req_ready` is 1 while `inv_all` is low, `resp_valid` and `fill_req` are 0, and every line is invalid.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| inv_all | input | 1 | Start invalidation of all lines (taken while idle) |
| req_ready | output | 1 | Block can take a request this cycle |
| req_valid | input | 1 | Request present |
| req_vaddr | input | 32 | Virtual byte address |
| req_we | input | 1 | 1 = write, 0 = read |
| req_be | input | 4 | Byte enables for writes |
| req_wdata | input | 32 | Write data |
| xl_paddr | input | 32 | Translated physical address, valid in the request cycle |
| xl_fault | input | 1 | Translation miss or access fault for this request |
| fill_req | output | 1 | Line fetch in progress |
| fill_addr | output | 32 | Physical line base address to fetch |
| fill_valid | input | 1 | A fill beat is present |
| fill_data | input | 32 | Fill beat data |
| resp_valid | output | 1 | Response present (one cycle) |
| resp_hit | output | 1 | Request hit in the cache |
| resp_err | output | 1 | Request faulted in translation |
| resp_rdata | output | 32 | Read data |

## Verification
The assertions check several properties on every cycle:
- at most one way hits;
- a fault yields an error response and no fetch;
- a write miss starts no fetch;
- `fill_addr` holds while `fill_req` is high;
- the response is a single-cycle pulse;
- `req_ready` is low during the invalidation sweep;
- a touched way is never the next victim in its set.

Only the bench scenarios can show the end-to-end behaviour: the returned data, the two separate alias copies, the exact pseudo-LRU eviction order and the 128-cycle sweep length. For these, the bench sweeps many sets and every word of each line, and computes the memory contents arithmetically from the address.

// File: rtl/vipt_pkg.sv
package vipt_pkg;

  localparam int NUM_WAYS = 4;

  typedef enum logic [1:0] {
    ST_IDLE,
    ST_LOOK,
    ST_FILL,
    ST_INV
  } cstate_t;

  // Tree bit 0: 0 -> victim among ways 0/1, 1 -> among ways 2/3.
  // Bit 1 picks way 1 over 0, bit 2 picks way 3 over 2.
  function automatic logic [1:0] plru_victim(input logic [2:0] t);
    if (!t[0]) return t[1] ? 2'd1 : 2'd0;
    else       return t[2] ? 2'd3 : 2'd2;
  endfunction

  function automatic logic [2:0] plru_touch(input logic [2:0] t, input logic [1:0] w);
    logic [2:0] r;
    r    = t;
    r[0] = ~w[1];
    if (!w[1]) r[1] = ~w[0];
    else       r[2] = ~w[0];
    return r;
  endfunction

endpackage

// File: rtl/vipt_way_mem.sv
module vipt_way_mem #(
  parameter int TAG_W  = 22,
  parameter int IDX_W  = 7,
  parameter int WORD_W = 2,
  parameter int DATA_W = 32
) (
  input  logic                       clk,
  input  logic                       rd_en,
  input  logic [IDX_W-1:0]           set_i,
  input  logic [WORD_W-1:0]          word_i,
  input  logic                       tag_we,
  input  logic [TAG_W-1:0]           tag_i,
  input  logic [DATA_W/8-1:0]        be_i,
  input  logic [DATA_W-1:0]          wdata_i,
  output logic [TAG_W-1:0]           tag_o,
  output logic [DATA_W-1:0]          data_o
);
  localparam int SETS   = 1 << IDX_W;
  localparam int DWORDS = 1 << (IDX_W + WORD_W);
  localparam int BE_W   = DATA_W / 8;

  logic [TAG_W-1:0]  tag_mem  [SETS];
  logic [DATA_W-1:0] data_mem [DWORDS];
  logic [IDX_W+WORD_W-1:0] daddr;

  assign daddr = {set_i, word_i};

  // Single-port tag array with registered read
  always_ff @(posedge clk) begin
    if (tag_we)      tag_mem[set_i] <= tag_i;
    else if (rd_en)  tag_o <= tag_mem[set_i];
  end

  // Single-port data array, byte-writable, registered read
  always_ff @(posedge clk) begin
    for (int b = 0; b < BE_W; b++) begin
      if (be_i[b]) data_mem[daddr][b*8 +: 8] <= wdata_i[b*8 +: 8];
    end
    if (rd_en) data_o <= data_mem[daddr];
  end

endmodule

// File: rtl/vipt_plru.sv
module vipt_plru
  import vipt_pkg::*;
#(
  parameter int SETS = 128
) (
  input  logic                     clk,
  input  logic                     rst,
  input  logic [$clog2(SETS)-1:0]  set_i,
  output logic [1:0]               victim_o,
  input  logic                     touch_en,
  input  logic [$clog2(SETS)-1:0]  touch_set,
  input  logic [1:0]               touch_way
);
  logic [2:0] tree_q [SETS];

  always_ff @(posedge clk) begin
    if (rst) begin
      for (int s = 0; s < SETS; s++) tree_q[s] <= '0;
    end else if (touch_en) begin
      tree_q[touch_set] <= plru_touch(tree_q[touch_set], touch_way);
    end
  end

  assign victim_o = plru_victim(tree_q[set_i]);

  // R8: the way just used is never the next victim of its set
  p_touched_not_victim_r8: assert property (@(posedge clk) disable iff (rst)
    touch_en |=> (plru_victim(tree_q[$past(touch_set)]) != $past(touch_way)));

endmodule

// File: rtl/vipt_cache.sv
module vipt_cache
  import vipt_pkg::*;
#(
  parameter int ADDR_W      = 32,
  parameter int DATA_W      = 32,
  parameter int CACHE_BYTES = 8192,
  parameter int LINE_BYTES  = 16,
  parameter int PAGE_BITS   = 10
) (
  input  logic                 clk,
  input  logic                 rst,
  input  logic                 inv_all,
  output logic                 req_ready,
  input  logic                 req_valid,
  input  logic [ADDR_W-1:0]    req_vaddr,
  input  logic                 req_we,
  input  logic [DATA_W/8-1:0]  req_be,
  input  logic [DATA_W-1:0]    req_wdata,
  input  logic [ADDR_W-1:0]    xl_paddr,
  input  logic                 xl_fault,
  output logic                 fill_req,
  output logic [ADDR_W-1:0]    fill_addr,
  input  logic                 fill_valid,
  input  logic [DATA_W-1:0]    fill_data,
  output logic                 resp_valid,
  output logic                 resp_hit,
  output logic                 resp_err,
  output logic [DATA_W-1:0]    resp_rdata
);
  localparam int BE_W    = DATA_W / 8;
  localparam int BOFF_W  = $clog2(BE_W);
  localparam int OFF_W   = $clog2(LINE_BYTES);
  localparam int WORD_W  = OFF_W - BOFF_W;
  localparam int WORDS   = 1 << WORD_W;
  localparam int SETS    = CACHE_BYTES / (NUM_WAYS * LINE_BYTES);
  localparam int IDX_W   = $clog2(SETS);
  localparam int IDX_TOP = OFF_W + IDX_W;
  localparam int TAG_LSB = (PAGE_BITS < IDX_TOP) ? PAGE_BITS : IDX_TOP;
  localparam int TAG_W   = ADDR_W - TAG_LSB;
  localparam int LINE_W  = ADDR_W - OFF_W;

  cstate_t               state_q;
  logic [IDX_W-1:0]      set_q, inv_cnt_q;
  logic [WORD_W-1:0]     word_q, beat_q;
  logic                  we_q, fault_q;
  logic [BE_W-1:0]       be_q;
  logic [DATA_W-1:0]     wdata_q, cap_q;
  logic [LINE_W-1:0]     pline_q;
  logic [1:0]            victim_q, victim;
  logic [NUM_WAYS-1:0]   valid_q [SETS];

  logic                  accept, last_beat, any_hit, touch_en;
  logic [IDX_W-1:0]      va_set, mem_set;
  logic [WORD_W-1:0]     va_word, mem_word;
  logic [DATA_W-1:0]     mem_wdata, hit_data;
  logic [TAG_W-1:0]      ptag;
  logic [NUM_WAYS-1:0]   hit_vec;
  logic [1:0]            hit_way, touch_way;
  logic [TAG_W-1:0]      tag_rd  [NUM_WAYS];
  logic [DATA_W-1:0]     data_rd [NUM_WAYS];

  logic unused_addr_bits;
  assign unused_addr_bits = ^{req_vaddr[ADDR_W-1:IDX_TOP], req_vaddr[BOFF_W-1:0],
                              xl_paddr[OFF_W-1:0]};

  assign req_ready = (state_q == ST_IDLE) && !inv_all;
  assign accept    = req_ready && req_valid;
  assign va_set    = req_vaddr[IDX_TOP-1:OFF_W];
  assign va_word   = req_vaddr[OFF_W-1:BOFF_W];
  assign ptag      = pline_q[LINE_W-1:TAG_LSB-OFF_W];
  assign last_beat = (state_q == ST_FILL) && fill_valid && (beat_q == WORD_W'(WORDS-1));

  // Arrays are addressed by the virtual index on the accepting edge
  assign mem_set   = accept ? va_set : set_q;
  assign mem_word  = accept ? va_word : ((state_q == ST_FILL) ? beat_q : word_q);
  assign mem_wdata = (state_q == ST_FILL) ? fill_data : wdata_q;

  // Physical tag compare in the cycle after the array read
  always_comb begin
    hit_data = '0;
    hit_way  = '0;
    for (int w = 0; w < NUM_WAYS; w++) begin
      hit_vec[w] = valid_q[set_q][w] && (tag_rd[w] == ptag);
      if (hit_vec[w]) begin
        hit_data = hit_data | data_rd[w];
        hit_way  = 2'(w);
      end
    end
  end
  assign any_hit = (state_q == ST_LOOK) && !fault_q && (|hit_vec);

  for (genvar w = 0; w < NUM_WAYS; w++) begin : g_way
    logic            tag_we_w;
    logic [BE_W-1:0] be_w;
    assign tag_we_w = last_beat && (victim_q == 2'(w));
    assign be_w = ((state_q == ST_FILL) && fill_valid && (victim_q == 2'(w))) ? {BE_W{1'b1}} :
                  ((state_q == ST_LOOK) && we_q && !fault_q && hit_vec[w]) ? be_q : '0;
    vipt_way_mem #(.TAG_W(TAG_W), .IDX_W(IDX_W), .WORD_W(WORD_W), .DATA_W(DATA_W)) u_mem (
      .clk    (clk),
      .rd_en  (accept),
      .set_i  (mem_set),
      .word_i (mem_word),
      .tag_we (tag_we_w),
      .tag_i  (ptag),
      .be_i   (be_w),
      .wdata_i(mem_wdata),
      .tag_o  (tag_rd[w]),
      .data_o (data_rd[w])
    );
  end

  assign touch_en  = any_hit || last_beat;
  assign touch_way = last_beat ? victim_q : hit_way;

  vipt_plru #(.SETS(SETS)) u_plru (
    .clk      (clk),
    .rst      (rst),
    .set_i    (set_q),
    .victim_o (victim),
    .touch_en (touch_en),
    .touch_set(set_q),
    .touch_way(touch_way)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      state_q    <= ST_IDLE;
      set_q      <= '0;
      inv_cnt_q  <= '0;
      word_q     <= '0;
      beat_q     <= '0;
      we_q       <= 1'b0;
      fault_q    <= 1'b0;
      be_q       <= '0;
      wdata_q    <= '0;
      cap_q      <= '0;
      pline_q    <= '0;
      victim_q   <= '0;
      fill_req   <= 1'b0;
      fill_addr  <= '0;
      resp_valid <= 1'b0;
      resp_hit   <= 1'b0;
      resp_err   <= 1'b0;
      resp_rdata <= '0;
      for (int s = 0; s < SETS; s++) valid_q[s] <= '0;
    end else begin
      resp_valid <= 1'b0;
      resp_hit   <= 1'b0;
      resp_err   <= 1'b0;
      case (state_q)
        ST_IDLE: begin
          if (inv_all) begin
            inv_cnt_q <= '0;
            state_q   <= ST_INV;
          end else if (req_valid) begin
            set_q   <= va_set;
            word_q  <= va_word;
            we_q    <= req_we;
            be_q    <= req_be;
            wdata_q <= req_wdata;
            pline_q <= xl_paddr[ADDR_W-1:OFF_W];
            fault_q <= xl_fault;
            state_q <= ST_LOOK;
          end
        end
        ST_LOOK: begin
          if (fault_q) begin
            resp_valid <= 1'b1;
            resp_err   <= 1'b1;
            state_q    <= ST_IDLE;
          end else if (|hit_vec) begin
            resp_valid <= 1'b1;
            resp_hit   <= 1'b1;
            resp_rdata <= hit_data;
            state_q    <= ST_IDLE;
          end else if (we_q) begin
            resp_valid <= 1'b1;
            state_q    <= ST_IDLE;
          end else begin
            fill_req  <= 1'b1;
            fill_addr <= {pline_q, {OFF_W{1'b0}}};
            victim_q  <= victim;
            beat_q    <= '0;
            state_q   <= ST_FILL;
          end
        end
        ST_FILL: begin
          if (fill_valid) begin
            beat_q <= beat_q + 1'b1;
            if (beat_q == word_q) cap_q <= fill_data;
            if (beat_q == WORD_W'(WORDS-1)) begin
              valid_q[set_q][victim_q] <= 1'b1;
              fill_req   <= 1'b0;
              resp_valid <= 1'b1;
              resp_rdata <= (beat_q == word_q) ? fill_data : cap_q;
              state_q    <= ST_IDLE;
            end
          end
        end
        ST_INV: begin
          valid_q[inv_cnt_q] <= '0;
          inv_cnt_q <= inv_cnt_q + 1'b1;
          if (inv_cnt_q == IDX_W'(SETS-1)) state_q <= ST_IDLE;
        end
        default: state_q <= ST_IDLE;
      endcase
    end
  end

  // R3: a set never holds two valid copies of one physical tag
  p_single_hit_r3: assert property (@(posedge clk) disable iff (rst)
    (state_q == ST_LOOK) |-> $onehot0(hit_vec));

  // R6: a faulted lookup answers with an error and starts no fetch
  p_fault_no_fill_r6: assert property (@(posedge clk) disable iff (rst)
    (state_q == ST_LOOK && fault_q) |=> (resp_err && !fill_req));

  p_err_not_hit_r6: assert property (@(posedge clk) disable iff (rst)
    resp_err |-> !resp_hit);

  // R10: a write lookup never starts a fetch
  p_write_no_fill_r10: assert property (@(posedge clk) disable iff (rst)
    (state_q == ST_LOOK && we_q) |=> !fill_req);

  // R7: the fetch address holds while the fetch is outstanding
  p_fill_addr_hold_r7: assert property (@(posedge clk) disable iff (rst)
    (fill_req && $past(fill_req)) |-> $stable(fill_addr));

  // R2: each response is a single-cycle pulse
  p_resp_pulse_r2: assert property (@(posedge clk) disable iff (rst)
    resp_valid |=> !resp_valid);

  // R11: no request is taken during the sweep
  p_inv_stall_r11: assert property (@(posedge clk) disable iff (rst)
    (state_q == ST_INV) |-> !req_ready);

endmodule

// File: tb/vipt_cache_test.sv
module vipt_cache_test;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        inv_all = 1'b0;
  logic        req_ready;
  logic        req_valid = 1'b0;
  logic [31:0] req_vaddr = '0;
  logic        req_we = 1'b0;
  logic [3:0]  req_be = '0;
  logic [31:0] req_wdata = '0;
  logic [31:0] xl_paddr = '0;
  logic        xl_fault = 1'b0;
  logic        fill_req;
  logic [31:0] fill_addr;
  logic        fill_valid = 1'b0;
  logic [31:0] fill_data = '0;
  logic        resp_valid, resp_hit, resp_err;
  logic [31:0] resp_rdata;

  int checks = 0;
  int fails  = 0;
  int fills  = 0;
  int mcnt   = 0;
  logic fill_prev = 1'b0;
  logic [31:0] last_fill_addr = '0;

  always #2 clk = ~clk;

  vipt_cache uut (
    .clk(clk), .rst(rst), .inv_all(inv_all), .req_ready(req_ready),
    .req_valid(req_valid), .req_vaddr(req_vaddr), .req_we(req_we),
    .req_be(req_be), .req_wdata(req_wdata), .xl_paddr(xl_paddr),
    .xl_fault(xl_fault), .fill_req(fill_req), .fill_addr(fill_addr),
    .fill_valid(fill_valid), .fill_data(fill_data), .resp_valid(resp_valid),
    .resp_hit(resp_hit), .resp_err(resp_err), .resp_rdata(resp_rdata)
  );

  function automatic logic [31:0] memf(input logic [31:0] a);
    return {a[15:0] ^ 16'h3C5A, ~a[15:0]};
  endfunction

  task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  // Memory model: one beat per cycle, word order 0..3
  always @(negedge clk) begin
    if (fill_req && !fill_prev) begin
      fills++;
      last_fill_addr = fill_addr;
    end
    fill_prev = fill_req;
    if (fill_req && mcnt < 4) begin
      fill_valid = 1'b1;
      fill_data  = memf(fill_addr + 32'(4 * mcnt));
      mcnt++;
    end else begin
      fill_valid = 1'b0;
      if (!fill_req) mcnt = 0;
    end
  end

  logic        r_hit, r_err;
  logic [31:0] r_data;
  int          r_lat;

  task automatic access(input logic [31:0] va, input logic [31:0] pa, input bit flt,
                        input bit we, input logic [3:0] be, input logic [31:0] wd);
    while (!req_ready) @(negedge clk);
    req_valid = 1'b1; req_vaddr = va; xl_paddr = pa; xl_fault = flt;
    req_we = we; req_be = be; req_wdata = wd;
    @(negedge clk);
    req_valid = 1'b0; xl_fault = 1'b0;
    r_lat = 1;
    while (!resp_valid && r_lat < 200) begin
      @(negedge clk);
      r_lat++;
    end
    r_hit = resp_hit; r_err = resp_err; r_data = resp_rdata;
    @(negedge clk);
  endtask

  task automatic rd(input logic [31:0] va, input logic [31:0] pa);
    access(va, pa, 1'b0, 1'b0, 4'h0, 32'h0);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    fails++;
    checks++;
    $display("FAIL watchdog actual=%h expected=%h", 32'd0, 32'd1);
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

  initial begin
    int f0;
    logic [31:0] a, exp;
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    // R12 reset state
    chk(req_ready == 1'b1, "R12 ready", 32'(req_ready), 32'd1);
    chk(resp_valid == 1'b0 && fill_req == 1'b0, "R12 idle outputs",
        {30'd0, resp_valid, fill_req}, 32'd0);

    // R1/R5/R7: identity-mapped sweep over 8 sets, every word of each line
    for (int s = 0; s < 8; s++) begin
      a = 32'h0002_0000 + 32'(s * 9 * 16);
      f0 = fills;
      rd(a + 32'd4, a + 32'd4);
      chk(r_hit == 1'b0 && fills == f0 + 1, "R7 read miss fetch", 32'(fills - f0), 32'd1);
      chk(last_fill_addr == a, "R7 fill line address", last_fill_addr, a);
      chk(r_data == memf(a + 32'd4), "R7 miss data word1", r_data, memf(a + 32'd4));
      for (int w = 0; w < 4; w++) begin
        rd(a + 32'(4 * w), a + 32'(4 * w));
        chk(r_hit == 1'b1, "R5 identity hit", 32'(r_hit), 32'd1);
        chk(r_data == memf(a + 32'(4 * w)), "R1 word select", r_data, memf(a + 32'(4 * w)));
        chk(r_lat == 2, "R2 hit latency", 32'(r_lat), 32'd2);
      end
    end

    // R4: aliases VA 0x1000 (set 0x00) and VA 0x1400 (set 0x40) -> PA 0x1000
    f0 = fills;
    rd(32'h1000, 32'h1000);
    rd(32'h1400, 32'h1000);
    chk(fills == f0 + 2 && r_hit == 1'b0, "R4 alias second fetch", 32'(fills - f0), 32'd2);
    rd(32'h1400, 32'h1000);
    chk(r_hit == 1'b1, "R4 alias copy hits", 32'(r_hit), 32'd1);
    // R9: byte-enable write hit through the first alias
    access(32'h1000, 32'h1000, 1'b0, 1'b1, 4'b0101, 32'h1122_3344);
    chk(r_hit == 1'b1, "R9 write hit", 32'(r_hit), 32'd1);
    exp = (memf(32'h1000) & 32'hFF00_FF00) | (32'h1122_3344 & 32'h00FF_00FF);
    rd(32'h1000, 32'h1000);
    chk(r_data == exp, "R9 byte merge", r_data, exp);
    rd(32'h1400, 32'h1000);
    chk(r_data == memf(32'h1000) && r_hit, "R4 other copy unchanged", r_data, memf(32'h1000));
    // R3: translated bit 10 is part of the tag: VA 0x1000 with PA 0x1400 misses
    f0 = fills;
    rd(32'h1000, 32'h1400);
    chk(r_hit == 1'b0 && fills == f0 + 1, "R3 translated bit compared", 32'(r_hit), 32'd0);

    // R10: write miss
    f0 = fills;
    access(32'h0003_0050, 32'h0003_0050, 1'b0, 1'b1, 4'hF, 32'hDEAD_BEEF);
    chk(r_hit == 1'b0 && fills == f0, "R10 write miss no fetch", 32'(fills - f0), 32'd0);
    rd(32'h0003_0050, 32'h0003_0050);
    chk(r_hit == 1'b0 && r_data == memf(32'h0003_0050), "R10 no allocate", r_data, memf(32'h0003_0050));

    // R6: faults
    f0 = fills;
    access(32'h0004_0060, 32'h0004_0060, 1'b1, 1'b0, 4'h0, 32'h0);
    chk(r_err == 1'b1 && r_hit == 1'b0 && fills == f0, "R6 fault uncached", {r_err, r_hit}, 32'h2);
    access(32'h0002_0000, 32'h0002_0000, 1'b1, 1'b0, 4'h0, 32'h0);
    chk(r_err == 1'b1 && r_hit == 1'b0, "R6 fault on cached line", {r_err, r_hit}, 32'h2);
    rd(32'h0002_0000, 32'h0002_0000);
    chk(r_hit == 1'b1 && fills == f0, "R6 line kept after fault", 32'(r_hit), 32'd1);

    // R8: five lines in set 0x0A; order 0,2,1,3, then way 0 (line A) evicted
    for (int k = 1; k <= 5; k++) begin
      a = 32'(k * 32'h800) + 32'h0A0;
      rd(a, a);
      chk(r_hit == 1'b0, "R8 fill line", 32'(r_hit), 32'd0);
    end
    for (int k = 2; k <= 5; k++) begin
      a = 32'(k * 32'h800) + 32'h0A0;
      rd(a, a);
      chk(r_hit == 1'b1, "R8 survivor hits", 32'(k), 32'(k));
    end
    rd(32'h08A0, 32'h08A0);
    chk(r_hit == 1'b0, "R8 oldest line evicted", 32'(r_hit), 32'd0);

    // R11: invalidate-all
    inv_all = 1'b1;
    @(negedge clk);
    inv_all = 1'b0;
    f0 = 0;
    while (!req_ready && f0 < 1000) begin
      f0++;
      @(negedge clk);
    end
    chk(f0 == 128, "R11 sweep length", 32'(f0), 32'd128);
    rd(32'h0002_0000, 32'h0002_0000);
    chk(r_hit == 1'b0, "R11 miss after sweep", 32'(r_hit), 32'd0);
    rd(32'h1400, 32'h1000);
    chk(r_hit == 1'b0, "R11 alias copy cleared", 32'(r_hit), 32'd0);

    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

endmodule